// File: doc/BRIEF.md
# Segmented DAC input decoder

This block is the digital front end of a segmented current-steering digital-to-analog converter. On each rising clock edge it captures one input word and a quadrature-invert flag into a register. Everything after that register is combinational, so the switch controls always follow the value that was captured last.

From the registered value the block forms an effective code. In quadrature mode every bit except the most significant one is complemented. The top bit then acts as a sign, so a phase accumulator only has to produce one quarter of a sine wave. The effective code is split in two. The low bits drive the binary-weighted ladder switches directly. The high bits are expanded into a thermometer of segment enables that fills from index zero upward.

A behavioural model of the two complementary output currents, counted in LSB units, is derived from the switch controls themselves. A bench can therefore check the steering that the analog cells would perform.

Top module: `segdac_front`

## Requirements
- R1: A synchronous active-high reset clears the captured word and the invert flag. For every cycle after a reset edge, and regardless of `din` and `inv`, `bin_ctl` is 0, `seg_en` is 0, `i_main` is 0 and `i_comp` is 1023.
- R2: Latency is exactly one clock. The outputs after a rising edge depend only on the `din` and `inv` sampled at that edge. Changing the inputs between edges leaves the outputs unchanged.
- R3: With `inv` = 0 the effective code equals `din` bit for bit.
- R4: With `inv` = 1, effective bits 0 to 8 are the complements of `din` bits 0 to 8, and effective bit 9 equals `din` bit 9.
- R5: `bin_ctl[5:0]` equals effective bits 5 to 0, with bit i of `bin_ctl` taken from effective bit i.
- R6: Let U be effective bits 9 to 6 read as an unsigned value (0 to 15). `seg_en[k]` is 1 exactly when U > k, for k = 0 to 14. The number of set enables equals U, and the set enables always form a contiguous run starting at bit 0.
- R7: `i_main` equals 64 times the number of set segment enables plus the value of `bin_ctl`. `i_comp` equals 1023 minus `i_main`, so the two always sum to 1023.
- R8: Three effective codes give fixed current splits:
  - effective code 1023 gives `i_main` = 1023 and `i_comp` = 0;
  - effective code 0 gives `i_main` = 0 and `i_comp` = 1023;
  - effective code 512 gives `i_main` = 512 (half of the 1024-unit full scale) and `i_comp` = 511.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 10 | Input code, bit 9 most significant |
| inv | input | 1 | Quadrature invert request, captured with `din` |
| bin_ctl | output | 6 | Binary-weighted ladder switch controls |
| seg_en | output | 15 | Thermometer segment enables, filling from bit 0 |
| i_main | output | 10 | Modelled main-output current in LSB units |
| i_comp | output | 10 | Modelled complementary-output current in LSB units |

## Verification
The bench builds the block with its default widths: a 10-bit word with a 6-bit binary part, which gives 4 thermometer bits and 15 segments. These widths are small enough to sweep every one of the 1024 codes in both invert modes, so every thermometer boundary, every major carry and every sign-preserving inversion is checked against an integer model.

Two further kinds of stimulus are added:
- directed corner codes and pseudo-random words, with input changes made between edges to test that the register is not transparent;
- a reset applied while the inputs are at full scale.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

    // Default widths of the converter word and of its binary-weighted part.
    localparam int DEF_DATA_W = 10;
    localparam int DEF_BIN_W  = 6;

    // Captured invert request.
    typedef enum logic {
        INV_PASS = 1'b0,
        INV_QUAD = 1'b1
    } inv_mode_e;

    // Number of unary segments produced by a thermometer of the given width.
    function automatic int seg_count(input int therm_w);
        return (1 << therm_w) - 1;
    endfunction

    // Full scale minus one LSB, in LSB units.
    function automatic int full_scale_m1(input int data_w);
        return (1 << data_w) - 1;
    endfunction

endpackage

// File: rtl/segdac_capture.sv
module segdac_capture
    import segdac_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              inv,
    output logic [DATA_W-1:0] word_q,
    output inv_mode_e         mode_q
);

    // Data and invert flag share one register so they cannot slip apart.
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            mode_q <= INV_PASS;
        end else begin
            word_q <= din;
            mode_q <= inv ? INV_QUAD : INV_PASS;
        end
    end

endmodule

// File: rtl/segdac_quad.sv
module segdac_quad
    import segdac_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic [DATA_W-1:0] word,
    input  inv_mode_e         mode,
    output logic [DATA_W-1:0] eff
);

    logic flip;
    assign flip = (mode == INV_QUAD);

    // Every bit below the top one is complemented in quadrature mode.
    for (genvar b = 0; b < DATA_W - 1; b++) begin : g_mag
        assign eff[b] = word[b] ^ flip;
    end

    // The top bit acts as the sign and is never touched.
    assign eff[DATA_W-1] = word[DATA_W-1];

endmodule

// File: rtl/segdac_therm.sv
module segdac_therm
    import segdac_pkg::*;
#(
    parameter int THERM_W = DEF_DATA_W - DEF_BIN_W,
    localparam int SEG_N  = seg_count(THERM_W)
) (
    input  logic [THERM_W-1:0] upper,
    output logic [SEG_N-1:0]   seg_en
);

    // Enable k turns on once the upper value exceeds k, so the run fills from bit 0.
    for (genvar k = 0; k < SEG_N; k++) begin : g_seg
        assign seg_en[k] = (upper > THERM_W'(k));
    end

endmodule

// File: rtl/segdac_weight.sv
module segdac_weight
    import segdac_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int BIN_W   = DEF_BIN_W,
    localparam int THERM_W = DATA_W - BIN_W,
    localparam int SEG_N   = seg_count(THERM_W),
    localparam int FS_M1   = full_scale_m1(DATA_W)
) (
    input  logic [SEG_N-1:0]  seg_en,
    input  logic [BIN_W-1:0]  bin_ctl,
    output logic [DATA_W-1:0] i_main,
    output logic [DATA_W-1:0] i_comp
);

    logic [THERM_W-1:0] seg_on;

    // Count the active segments; each one carries 2**BIN_W LSB units.
    always_comb begin
        seg_on = '0;
        for (int k = 0; k < SEG_N; k++) begin
            seg_on = seg_on + THERM_W'(seg_en[k]);
        end
    end

    // Main current: active segment units plus the binary ladder value.
    assign i_main = {seg_on, bin_ctl};

    // Complementary output takes the rest of full scale minus one LSB.
    assign i_comp = DATA_W'(FS_M1) - i_main;

endmodule

// File: rtl/segdac_front.sv
module segdac_front
    import segdac_pkg::*;
#(
    parameter int DATA_W   = DEF_DATA_W,
    parameter int BIN_W    = DEF_BIN_W,
    localparam int THERM_W = DATA_W - BIN_W,
    localparam int SEG_N   = seg_count(THERM_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              inv,
    output logic [BIN_W-1:0]  bin_ctl,
    output logic [SEG_N-1:0]  seg_en,
    output logic [DATA_W-1:0] i_main,
    output logic [DATA_W-1:0] i_comp
);

    logic [DATA_W-1:0] word_q;
    inv_mode_e         mode_q;
    logic [DATA_W-1:0] eff;

    segdac_capture #(.DATA_W(DATA_W)) cap_i (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .inv    (inv),
        .word_q (word_q),
        .mode_q (mode_q)
    );

    segdac_quad #(.DATA_W(DATA_W)) quad_i (
        .word (word_q),
        .mode (mode_q),
        .eff  (eff)
    );

    // Low part of the effective code goes straight to the ladder.
    assign bin_ctl = eff[BIN_W-1:0];

    segdac_therm #(.THERM_W(THERM_W)) therm_i (
        .upper  (eff[DATA_W-1:BIN_W]),
        .seg_en (seg_en)
    );

    segdac_weight #(.DATA_W(DATA_W), .BIN_W(BIN_W)) weight_i (
        .seg_en  (seg_en),
        .bin_ctl (bin_ctl),
        .i_main  (i_main),
        .i_comp  (i_comp)
    );

    // Checks on the captured path and on the decoded controls.

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (seg_en == '0 && bin_ctl == '0)) else $error("reset clear"); // R1

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !inv |=> i_main == $past(din)) else $error("pass through"); // R3

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> i_main[DATA_W-1] == $past(din[DATA_W-1])) else $error("sign kept"); // R4

    AST_LADDER_LAT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> bin_ctl == ($past(inv) ? ~$past(din[BIN_W-1:0]) : $past(din[BIN_W-1:0])))
        else $error("ladder latency"); // R5

    AST_THERM_FILL: assert property (@(posedge clk) disable iff (rst)
        (seg_en & (seg_en + SEG_N'(1))) == '0) else $error("therm fill"); // R6

    AST_SEG_WEIGHT: assert property (@(posedge clk) disable iff (rst)
        int'(i_main[DATA_W-1:BIN_W]) == $countones(seg_en)) else $error("seg weight"); // R7

endmodule

// File: tb/segdac_front_tb.sv
`timescale 1ns/1ps
module segdac_front_tb_top;

    localparam int DW = 10;
    localparam int BW = 6;
    localparam int SN = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] din = '1;
    logic          inv = 1'b1;
    logic [BW-1:0] bin_ctl;
    logic [SN-1:0] seg_en;
    logic [DW-1:0] i_main;
    logic [DW-1:0] i_comp;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    int    pend_eff = 0;
    string pend_tag = "";
    bit    have     = 0;

    always #2 clk = ~clk;

    segdac_front dut_i (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .inv     (inv),
        .bin_ctl (bin_ctl),
        .seg_en  (seg_en),
        .i_main  (i_main),
        .i_comp  (i_comp)
    );

    // Behavioural reference: effective code from the input and invert request.
    function automatic int eff_of(input int d, input int i);
        if (i != 0) return (d & 512) | (511 - (d & 511));
        return d & 1023;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic compare_all(input int e, input string tag);
        int up;
        int segx;
        up   = e / 64;
        segx = 0;
        for (int k = 0; k < SN; k++) if (up > k) segx = segx | (1 << k);
        chk(tag, "effective code on i_main", int'(i_main), e);
        chk("R5", "bin_ctl", int'(bin_ctl), e % 64);
        chk("R6", "seg_en", int'(seg_en), segx);
        chk("R7", "i_main weight", int'(i_main), 64 * $countones(seg_en) + int'(bin_ctl));
        chk("R7", "i_comp", int'(i_comp), 1023 - e);
    endtask

    task automatic step(input int d, input int i, input string tag, input bit mid);
        int prev;
        @(negedge clk);
        if (have) compare_all(pend_eff, pend_tag);
        prev = int'(i_main);
        din = DW'(d);
        inv = i[0];
        pend_eff = eff_of(d, i);
        pend_tag = tag;
        have = 1;
        if (mid) begin
            #1;
            chk("R2", "output held between edges", int'(i_main), prev);
        end
    endtask

    task automatic do_reset(input int ncyc);
        @(negedge clk);
        if (have) compare_all(pend_eff, pend_tag);
        have = 0;
        rst = 1'b1;
        din = '1;
        inv = 1'b0;
        repeat (ncyc) @(negedge clk);
        chk("R1", "bin_ctl in reset", int'(bin_ctl), 0);
        chk("R1", "seg_en in reset", int'(seg_en), 0);
        chk("R1", "i_main in reset", int'(i_main), 0);
        chk("R1", "i_comp in reset", int'(i_comp), 1023);
        rst = 1'b0;
        pend_eff = eff_of(1023, 0);
        pend_tag = "R3";
        have = 1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        int lfsr;
        do_reset(3);
        // Corner codes for the fixed current splits.
        step(1023, 0, "R8", 1'b0);
        step(0,    0, "R8", 1'b1);
        step(512,  0, "R8", 1'b1);
        step(512,  1, "R8", 1'b1);
        step(0,    1, "R4", 1'b1);
        step(511,  0, "R3", 1'b0);
        step(63,   0, "R3", 1'b0);
        step(64,   0, "R3", 1'b0);
        step(63,   1, "R4", 1'b0);
        // Walking ones in both modes.
        for (int b = 0; b < DW; b++) begin
            step(1 << b, 0, "R3", 1'b1);
            step(1 << b, 1, "R4", 1'b1);
        end
        // Every code in both modes.
        for (int c = 0; c < 1024; c++) step(c, 0, "R3", 1'b0);
        for (int c = 0; c < 1024; c++) step(c, 1, "R4", 1'b0);
        // Pseudo-random words with a changing invert request.
        lfsr = 32'h1ACE;
        for (int n = 0; n < 400; n++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            step(lfsr & 1023, (lfsr >> 11) & 1, ((lfsr >> 11) & 1) != 0 ? "R4" : "R3", 1'b1);
        end
        // Reset in mid-run with the inputs at full scale.
        do_reset(2);
        step(700, 1, "R4", 1'b0);
        step(300, 0, "R3", 1'b0);
        @(negedge clk);
        if (have) compare_all(pend_eff, pend_tag);
        finish_up();
    end

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

endmodule